// File: doc/BRIEF.md
# Phase-Aligned Programmable Clock Divider

This block divides a fast input clock by a programmable integer for one output of a clock distribution tree. The output level stays high for a programmable number of fast cycles, then low for another programmable number, so the divide ratio and the duty cycle are set together. A chip uses one instance per output. All instances share one active-low alignment input. While that input is low, every taking-part divider holds a fixed level. When it rises, they all restart together, each after its own programmed phase delay.

An output can drop out of alignment in three ways: it can be masked, bypassed (the fast clock goes straight to the output), or powered down (the output sits low and the counter is idle). New settings never cut a period short. They are copied into a shadow set only on reset, on an alignment rising edge, or when the divider leaves bypass or power-down.

Top module: `phase_clk_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output takes the `cfg_start_high` level. After release, the divider behaves as if it had been restarted at the last reset edge.
- R2: A field value v in `cfg_high` or `cfg_low` means v+1 fast cycles. Once running, the output stays high for `cfg_high`+1 cycles and low for `cfg_low`+1 cycles, which gives a period of 2 to 32 cycles.
- R3: After a restart at edge k, the output holds the start level through edge k+P. It changes to the opposite level at edge k+P+1, where P is the effective phase offset.
- R4: A taking-part divider whose `align_n` is low at an edge drives the live `cfg_start_high` level from that edge on.
- R5: A rising edge of `align_n` restarts every taking-part divider. The restart copies the live settings and sets the output to the start level.
- R6: A masked divider (`cfg_no_align`=1) keeps running unchanged while `align_n` is low and when it rises.
- R7: With `cfg_bypass`=1 and no power-down, `div_out` equals `clk` and the counter is idle. The first edge after bypass is cleared restarts the divider.
- R8: With `cfg_power_down`=1, the output is low from the next edge on. The first edge after it is cleared restarts the divider.
- R9: Changes to ratio, duty or phase fields while the divider is running do not alter the running waveform.
- R10: A phase field P at or above the ratio acts as P modulo the ratio.
- R11: Dividers restarted by the same alignment edge keep a fixed relation: each follows its own R2/R3 waveform counted from that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| align_n | input | 1 | Shared alignment: hold while low, restart on rise |
| cfg_high | input | 4 | High-phase length minus one |
| cfg_low | input | 4 | Low-phase length minus one |
| cfg_phase | input | 5 | Phase offset in fast cycles |
| cfg_start_high | input | 1 | Level held while aligning and at restart |
| cfg_bypass | input | 1 | Pass the fast clock straight to the output |
| cfg_no_align | input | 1 | Mask this divider from alignment |
| cfg_power_down | input | 1 | Idle the counter and drive the output low |
| div_out | output | 1 | Divided clock output |

## Verification
The assertions assume that `align_n` and all settings are synchronous to `clk` and stable at each rising edge. They also assume that the phase field is wide enough to hold ratio minus one. The bench meets these assumptions by changing every input on the falling edge only. The bench uses default widths, where the phase field is one bit wider than the duty fields. Bypass is the one mode whose output is combinational from `clk`. The bench therefore samples it in both clock phases, not only after the rising edge.

// File: rtl/pcd_pkg.sv
// Package: shared state and command encodings for the phase-aligned divider.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package pcd_pkg;
    typedef enum logic [1:0] {
        PCD_IDLE  = 2'd0,
        PCD_HOLD  = 2'd1,
        PCD_DELAY = 2'd2,
        PCD_RUN   = 2'd3
    } pcd_state_e;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_HOLD = 2'd1,
        CMD_LOAD = 2'd2,
        CMD_RUN  = 2'd3
    } pcd_cmd_e;
endpackage

// File: rtl/pcd_align_ctrl.sv
// Alignment controller: decides, for each edge, whether the divider idles,
// holds, reloads or runs. It detects the alignment rising edge and the
// exit from bypass or power-down.
// Assumes align_n is synchronous to clk.
module pcd_align_ctrl
    import pcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     align_n,
    input  logic     bypass,
    input  logic     power_down,
    input  logic     no_align,
    output pcd_cmd_e cmd
);
    logic align_q;
    logic idle_q;
    logic idle;
    logic takes_part;

    assign idle       = bypass | power_down;
    assign takes_part = ~idle & ~no_align;

    // Remember last alignment level and idle status for edge detection.
    always_ff @(posedge clk) begin
        align_q <= align_n;
        idle_q  <= idle;
    end

    // Priority: idle, then hold, then restart, else keep counting.
    always_comb begin
        if (idle)
            cmd = CMD_IDLE;
        else if (takes_part && !align_n)
            cmd = CMD_HOLD;
        else if ((takes_part && !align_q) || idle_q)
            cmd = CMD_LOAD;
        else
            cmd = CMD_RUN;
    end

    logic unused_rst;
    assign unused_rst = rst_n;
endmodule

// File: rtl/pcd_shadow.sv
// Shadow settings: captures the duty fields on reset or reload and reduces
// the live phase field modulo the live ratio for the counter to load.
// Assumes PH_W >= CNT_W + 1, so that ratio minus one fits the phase width.
module pcd_shadow #(
    parameter int CNT_W = 4,
    parameter int PH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [PH_W-1:0]  cfg_phase,
    output logic [CNT_W-1:0] high_q,
    output logic [CNT_W-1:0] low_q,
    output logic [PH_W-1:0]  phase_eff
);
    localparam int RW   = CNT_W + 2;
    localparam int MW   = (PH_W + 1 > RW) ? PH_W + 1 : RW;
    localparam int ITER = 1 << (PH_W - 1);

    logic [MW-1:0] ratio;
    logic [MW-1:0] rem;

    // Live ratio from the encoded fields (each field stores length minus one).
    assign ratio = MW'(cfg_high) + MW'(cfg_low) + MW'(2);

    // Repeated subtraction bounded by the smallest ratio of two.
    always_comb begin
        rem = MW'(cfg_phase);
        for (int i = 0; i < ITER; i++) begin
            if (rem >= ratio)
                rem = rem - ratio;
        end
    end

    assign phase_eff = rem[PH_W-1:0];

    // Capture the duty fields only on reset or reload.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            high_q <= cfg_high;
            low_q  <= cfg_low;
        end
    end
endmodule

// File: rtl/pcd_counter.sv
// Period counter: counts the phase delay, then alternates between the high
// and low lengths held in the shadow set. Output is registered.
// Assumes the controller command and shadow values are valid each edge.
module pcd_counter
    import pcd_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int PH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pcd_cmd_e         cmd,
    input  logic [PH_W-1:0]  load_phase,
    input  logic             live_start,
    input  logic [CNT_W-1:0] high_q,
    input  logic [CNT_W-1:0] low_q,
    output logic             out_q,
    output pcd_state_e       state
);
    localparam int CW = (PH_W > CNT_W) ? PH_W : CNT_W;

    logic [CW-1:0] cnt;
    logic [CW-1:0] next_len;

    // Length minus one of the level that follows the current one.
    assign next_len = out_q ? CW'(low_q) : CW'(high_q);

    // Sequence through delay and run, or idle/hold as commanded.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd == CMD_LOAD) begin
            state <= PCD_DELAY;
            cnt   <= CW'(load_phase);
            out_q <= live_start;
        end else begin
            case (cmd)
                CMD_IDLE: begin
                    state <= PCD_IDLE;
                    cnt   <= '0;
                    out_q <= 1'b0;
                end
                CMD_HOLD: begin
                    state <= PCD_HOLD;
                    out_q <= live_start;
                end
                default: begin
                    if (state == PCD_DELAY || state == PCD_RUN) begin
                        if (cnt == '0) begin
                            out_q <= ~out_q;
                            state <= PCD_RUN;
                            cnt   <= next_len;
                        end else begin
                            cnt <= cnt - CW'(1);
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/phase_clk_divider.sv
// Top: one programmable divider output with shared alignment input.
// Assumes all inputs except clk change away from the rising clock edge.
module phase_clk_divider
    import pcd_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int PH_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_n,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [PH_W-1:0]  cfg_phase,
    input  logic             cfg_start_high,
    input  logic             cfg_bypass,
    input  logic             cfg_no_align,
    input  logic             cfg_power_down,
    output logic             div_out
);
    pcd_cmd_e         cmd;
    pcd_state_e       state;
    logic             out_q;
    logic [CNT_W-1:0] high_q;
    logic [CNT_W-1:0] low_q;
    logic [PH_W-1:0]  phase_eff;

    pcd_align_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .align_n    (align_n),
        .bypass     (cfg_bypass),
        .power_down (cfg_power_down),
        .no_align   (cfg_no_align),
        .cmd        (cmd)
    );

    pcd_shadow #(.CNT_W(CNT_W), .PH_W(PH_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd == CMD_LOAD),
        .cfg_high  (cfg_high),
        .cfg_low   (cfg_low),
        .cfg_phase (cfg_phase),
        .high_q    (high_q),
        .low_q     (low_q),
        .phase_eff (phase_eff)
    );

    pcd_counter #(.CNT_W(CNT_W), .PH_W(PH_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .load_phase (phase_eff),
        .live_start (cfg_start_high),
        .high_q     (high_q),
        .low_q      (low_q),
        .out_q      (out_q),
        .state      (state)
    );

    // Bypass passes the fast clock unless the output is powered down.
    assign div_out = (cfg_bypass && !cfg_power_down) ? clk : out_q;
endmodule

// File: rtl/pcd_checker.sv
// Checker: temporal properties of the divider, bound into every instance.
// Assumes inputs are stable at each rising edge of clk.
module pcd_checker
    import pcd_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       align_n,
    input logic       cfg_start_high,
    input logic       cfg_bypass,
    input logic       cfg_no_align,
    input logic       cfg_power_down,
    input logic       out_q,
    input pcd_state_e state
);
    logic             prev_out;
    logic [CNT_W:0]   same_len;
    logic             part;

    assign part = !cfg_bypass && !cfg_power_down && !cfg_no_align;

    // Track how long the running output has kept one level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_out <= 1'b0;
            same_len <= '0;
        end else begin
            prev_out <= out_q;
            if (state == PCD_RUN && out_q == prev_out)
                same_len <= same_len + 1'b1;
            else
                same_len <= '0;
        end
    end

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        same_len <= (CNT_W+1)'((1 << CNT_W) - 1));

    a_r4_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_n && part) |=> (out_q == $past(cfg_start_high)));

    a_r5_restart_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(align_n) && part) |=> (out_q == $past(cfg_start_high) && state == PCD_DELAY));

    a_r6_mask_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_no_align && !cfg_bypass && !cfg_power_down && state == PCD_RUN) |=> (state == PCD_RUN));

    a_r7_bypass_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass |=> (state == PCD_IDLE));

    a_r8_power_down_low: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_power_down |=> (!out_q && state == PCD_IDLE));
endmodule

bind phase_clk_divider pcd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .align_n        (align_n),
    .cfg_start_high (cfg_start_high),
    .cfg_bypass     (cfg_bypass),
    .cfg_no_align   (cfg_no_align),
    .cfg_power_down (cfg_power_down),
    .out_q          (out_q),
    .state          (state)
);

// File: tb/tb_phase_clk_divider.sv
module tb_phase_clk_divider;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic align_n = 1'b1;
    logic [3:0] c_hi [3];
    logic [3:0] c_lo [3];
    logic [4:0] c_ph [3];
    logic       c_sh [3];
    logic       c_byp [3];
    logic       c_nal [3];
    logic       c_pd [3];
    logic [2:0] dout;

    always #10 clk = ~clk;

    for (genvar g = 0; g < 3; g++) begin : g_div
        phase_clk_divider dut (
            .clk(clk), .rst_n(rst_n), .align_n(align_n),
            .cfg_high(c_hi[g]), .cfg_low(c_lo[g]), .cfg_phase(c_ph[g]),
            .cfg_start_high(c_sh[g]), .cfg_bypass(c_byp[g]),
            .cfg_no_align(c_nal[g]), .cfg_power_down(c_pd[g]),
            .div_out(dout[g])
        );
    end

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit chk_low = 0;

    // Reference model per divider: mode 0 off, 1 hold, 2 running, 3 bypass.
    int m_mode [3];
    int m_t [3];
    int m_h [3];
    int m_l [3];
    int m_p [3];
    int m_s [3];

    logic [2:0] exp_q [$];
    string      tag_q [$];
    string      cur_tag = "R1";

    task automatic check(input bit ok, input string req, input int got, input int want);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0d expected=%0d at %0t", req, got, want, $time);
        end
    endtask

    task automatic restart(input int i);
        m_mode[i] = 2;
        m_t[i] = 0;
        m_h[i] = c_hi[i] + 1;
        m_l[i] = c_lo[i] + 1;
        m_p[i] = c_ph[i] % (m_h[i] + m_l[i]);
        m_s[i] = c_sh[i];
    endtask

    task automatic hold(input int i);
        m_mode[i] = 1;
        m_s[i] = c_sh[i];
    endtask

    function automatic logic model_bit(input int i);
        int r, u, lf;
        case (m_mode[i])
            0: return 1'b0;
            1: return m_s[i][0];
            3: return 1'b1;
            default: begin
                r = m_h[i] + m_l[i];
                if (m_t[i] <= m_p[i]) return m_s[i][0];
                u = (m_t[i] - m_p[i] - 1) % r;
                lf = (m_s[i] != 0) ? m_l[i] : m_h[i];
                return (u < lf) ? !m_s[i][0] : m_s[i][0];
            end
        endcase
    endfunction

    // Driver: push expected items for n edges, then let them elapse.
    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            logic [2:0] e;
            for (int i = 0; i < 3; i++) begin
                e[i] = model_bit(i);
                if (m_mode[i] == 2) m_t[i]++;
            end
            exp_q.push_back(e);
            tag_q.push_back(cur_tag);
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (chk_low) begin
                #5;
                check(dout[2] == 1'b0, "R7 bypass low phase", dout[2], 0);
            end
        end
    endtask

    // Monitor: compare each output after every rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                for (int i = 0; i < 3; i++)
                    check(dout[i] === e[i], t, dout[i], e[i]);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // a: high 3, low 5, phase 2, start low
        c_hi[0] = 4'd2; c_lo[0] = 4'd4; c_ph[0] = 5'd2; c_sh[0] = 1'b0;
        // b: high 4, low 4, phase 0, start high
        c_hi[1] = 4'd3; c_lo[1] = 4'd3; c_ph[1] = 5'd0; c_sh[1] = 1'b1;
        // c: high 2, low 2, phase 31 -> 31 mod 4 = 3 (R10)
        c_hi[2] = 4'd1; c_lo[2] = 4'd1; c_ph[2] = 5'd31; c_sh[2] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            c_byp[i] = 1'b0; c_nal[i] = 1'b0; c_pd[i] = 1'b0; m_mode[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: last reset edge acts as the restart point
        cur_tag = "R1 reset level";
        for (int i = 0; i < 3; i++) restart(i);
        tick(1);
        rst_n = 1'b1;
        cur_tag = "R2 R3 R10 waveform after reset";
        tick(40);

        // R9: new fields while running leave the waveform alone
        c_hi[0] = 4'd5; c_lo[0] = 4'd1; c_ph[0] = 5'd1; c_sh[0] = 1'b1;
        cur_tag = "R9 running ignores new fields";
        tick(30);

        // R4: hold at live start level
        align_n = 1'b0;
        for (int i = 0; i < 3; i++) hold(i);
        cur_tag = "R4 hold level";
        tick(8);

        // R5 R11: common restart with new settings
        align_n = 1'b1;
        for (int i = 0; i < 3; i++) restart(i);
        cur_tag = "R5 R11 aligned restart";
        tick(50);

        // R6: mask c, then hold and restart a, b only
        c_nal[2] = 1'b1;
        align_n = 1'b0;
        hold(0); hold(1);
        cur_tag = "R6 masked keeps running";
        tick(8);
        align_n = 1'b1;
        restart(0); restart(1);
        tick(20);

        // R7: bypass c, output follows the fast clock
        c_byp[2] = 1'b1;
        m_mode[2] = 3;
        cur_tag = "R7 bypass high phase";
        chk_low = 1'b1;
        tick(6);
        chk_low = 1'b0;
        c_byp[2] = 1'b0;
        c_nal[2] = 1'b0;
        restart(2);
        cur_tag = "R7 restart after bypass";
        tick(20);

        // R8: power down c, then release
        c_pd[2] = 1'b1;
        m_mode[2] = 0;
        cur_tag = "R8 power-down low";
        tick(6);
        c_pd[2] = 1'b0;
        restart(2);
        cur_tag = "R8 restart after power-down";
        tick(25);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule